// File: doc/BRIEF.md
# Sign-Magnitude Restoring Integer Divider

This block divides one sign-magnitude integer by another. Each operand has a 35-bit magnitude and a separate sign bit. When a start strobe arrives, the block captures both operands together with a 2-bit sign-modifier code and works one clock at a time. First it shifts dividend and divisor left together until one of them has its top magnitude bit set. Next it shifts the divisor alone until the divisor is normalised, counting those shifts. It then runs one restoring compare/subtract step per clock. When it finishes, it leaves the quotient magnitude and sign on the quotient outputs and an unsigned remainder magnitude on the remainder output, and it pulses a done strobe. A zero divisor ends the operation at once and raises the error flag.

The controller is a five-state machine:
- **IDLE** waits for start. If either operand is zero it takes the *early exit* transition straight to DONE. Otherwise it takes the *capture* transition to JOINT.
- **JOINT** shifts both magnitudes left while neither top bit is set.
  - *shortcut*: if only the divisor reached the top bit, it goes to DONE with a zero quotient.
  - *aligned*: otherwise it goes to ALIGN.
- **ALIGN** shifts the divisor alone and counts the shifts n. The *normalised* transition leads to STEP.
- **STEP** performs n+1 divide steps. After the last one it takes the *finish* transition to DONE.
- **DONE** raises done for one cycle and returns to IDLE on the *release* transition.

The remainder is reported with the same left scaling as the normalised divisor: it equals (|dividend| mod |divisor|) shifted left by the divisor's leading-zero count. Software must shift it back if it needs the true remainder.

Top module: `smag_divider`

## Requirements
- R1: When the divide completes through the STEP state with sign_mod = 00, quo_sign equals dvd_sign XOR dvs_sign.
- R2: A zero divisor magnitude gives the following on the done cycle: div_err = 1, quo_mag = 0, rem_mag = 0, and quo_sign = dvd_sign XOR dvs_sign. Done rises one cycle after the start edge.
- R3: A zero dividend magnitude with a nonzero divisor gives div_err = 0, quo_mag = 0, rem_mag = 0, and quo_sign = dvd_sign XOR dvs_sign with sign_mod ignored. Done rises one cycle after the start edge.
- R4: On the full divide path, quo_mag = floor(|a|/|b|) and rem_mag = (|a| mod |b|) << lz(b). Here lz is the leading-zero count in the 35-bit field. This path is taken when lz(b) >= lz(a).
- R5: When lz(b) < lz(a) (the shortcut), quo_mag = 0, rem_mag = |a| << lz(b), div_err = 0, and quo_sign = dvd_sign XOR dvs_sign with sign_mod ignored.
- R6: On the full divide path, sign_mod changes the XOR sign as follows: 00 keeps it, 01 forces 0, 10 forces 1, 11 inverts it.
- R7: Counting the edge that samples start as edge 1, done is high in the cycle after edge L:
  - zero operand: L = 1
  - shortcut: L = lz(b) + 2
  - full path: L = lz(a) + 2·(lz(b) − lz(a)) + 4
- R8: done is high for exactly one cycle. quo_mag, quo_sign, rem_mag and div_err change only when done rises, and they hold their values until the next completion.
- R9: start is ignored in every state other than IDLE, including the DONE cycle. Operands presented then do not affect the running or the next result.
- R10: After reset, done = 0, div_err = 0, quo_sign = 0, quo_mag = 0 and rem_mag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide; sampled in IDLE only |
| dvd_mag | input | 35 | Dividend magnitude |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvs_mag | input | 35 | Divisor magnitude |
| dvs_sign | input | 1 | Divisor sign (1 = negative) |
| sign_mod | input | 2 | Result-sign modifier: 00 keep, 01 clear, 10 set, 11 invert |
| quo_mag | output | 35 | Quotient magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_mag | output | 35 | Scaled remainder magnitude, unsigned |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide exception (zero divisor), held with the result |

## Verification
The counts of joint and divisor-only shifts set the latency, so a wrong shift decision shows up as a wrong done cycle. Such a fault appears within the same operation, one or more cycles before or after the reference model expects done. The same applies to a wrong normalisation test or an off-by-one in the step count. An error inside the subtract datapath corrupts the quotient or the scaled remainder, and the bench sees it on the done cycle itself. The bench compares done on every clock against a latency it computes from the leading-zero counts. It also checks that results hold between completions, so a stray update or an accepted mid-run start is caught one cycle after it happens.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_JOINT,
        ST_ALIGN,
        ST_STEP,
        ST_DONE
    } sdiv_state_t;

    typedef enum logic [1:0] {
        SMOD_KEEP   = 2'b00,
        SMOD_CLEAR  = 2'b01,
        SMOD_SET    = 2'b10,
        SMOD_INVERT = 2'b11
    } smod_t;
endpackage

// File: rtl/sdiv_sign_mod.sv
module sdiv_sign_mod
    import sdiv_pkg::*;
(
    input  logic       sign_in,
    input  logic [1:0] mode,
    output logic       sign_out
);
    always_comb begin
        unique case (smod_t'(mode))
            SMOD_KEEP:   sign_out = sign_in;
            SMOD_CLEAR:  sign_out = 1'b0;
            SMOD_SET:    sign_out = 1'b1;
            SMOD_INVERT: sign_out = ~sign_in;
            default:     sign_out = sign_in;
        endcase
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int MAG_W = 35
) (
    input  logic [MAG_W:0]   rem_in,
    input  logic [MAG_W-1:0] dvs,
    input  logic [MAG_W-1:0] quo_in,
    input  logic             last,
    output logic [MAG_W:0]   rem_out,
    output logic [MAG_W-1:0] quo_out
);
    logic             fits;
    logic [MAG_W:0]   dvs_ext;
    logic [MAG_W:0]   diff;

    always_comb begin
        dvs_ext = {1'b0, dvs};
        fits    = (rem_in >= dvs_ext);
        diff    = fits ? (rem_in - dvs_ext) : rem_in;
        // the final step omits the shift, folding in the trailing right shift
        rem_out = last ? diff : {diff[MAG_W-1:0], 1'b0};
        quo_out = {quo_in[MAG_W-2:0], fits};
    end
endmodule

// File: rtl/smag_divider.sv
module smag_divider
    import sdiv_pkg::*;
#(
    parameter int HI_W = 17,
    parameter int LO_W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [HI_W+LO_W-1:0]   dvd_mag,
    input  logic                   dvd_sign,
    input  logic [HI_W+LO_W-1:0]   dvs_mag,
    input  logic                   dvs_sign,
    input  logic [1:0]             sign_mod,
    output logic [HI_W+LO_W-1:0]   quo_mag,
    output logic                   quo_sign,
    output logic [HI_W+LO_W-1:0]   rem_mag,
    output logic                   done,
    output logic                   div_err
);
    localparam int MAG_W = HI_W + LO_W;
    localparam int MSB   = MAG_W - 1;
    localparam int CNT_W = $clog2(MAG_W + 1);

    sdiv_state_t        state, nxt;
    logic [MAG_W:0]     a_r;
    logic [MAG_W-1:0]   b_r;
    logic [MAG_W-1:0]   q_r;
    logic [CNT_W-1:0]   n_r;
    logic [CNT_W-1:0]   i_r;
    logic               sx_r;
    logic [1:0]         mod_r;

    logic [MAG_W-1:0]   res_q;
    logic [MAG_W-1:0]   res_r;
    logic               res_s;
    logic               res_err;

    logic               last_step;
    logic [MAG_W:0]     step_rem;
    logic [MAG_W-1:0]   step_q;
    logic               mod_sign;
    logic               zero_dvs;
    logic               zero_dvd;
    logic               neither_norm;
    logic               only_dvs_norm;

    assign last_step     = (i_r == n_r);
    assign zero_dvs      = (dvs_mag == '0);
    assign zero_dvd      = (dvd_mag == '0);
    assign neither_norm  = !a_r[MSB] && !b_r[MSB];
    assign only_dvs_norm = b_r[MSB] && !a_r[MSB];

    sdiv_step #(.MAG_W(MAG_W)) u_step (
        .rem_in  (a_r),
        .dvs     (b_r),
        .quo_in  (q_r),
        .last    (last_step),
        .rem_out (step_rem),
        .quo_out (step_q)
    );

    sdiv_sign_mod u_smod (
        .sign_in  (sx_r),
        .mode     (mod_r),
        .sign_out (mod_sign)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = (zero_dvs || zero_dvd) ? ST_DONE : ST_JOINT;
            end
            ST_JOINT: begin
                if (!neither_norm) nxt = only_dvs_norm ? ST_DONE : ST_ALIGN;
            end
            ST_ALIGN: begin
                if (b_r[MSB]) nxt = ST_STEP;
            end
            ST_STEP: begin
                if (last_step) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r     <= '0;
            b_r     <= '0;
            q_r     <= '0;
            n_r     <= '0;
            i_r     <= '0;
            sx_r    <= 1'b0;
            mod_r   <= 2'b00;
            res_q   <= '0;
            res_r   <= '0;
            res_s   <= 1'b0;
            res_err <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_r   <= {1'b0, dvd_mag};
                        b_r   <= dvs_mag;
                        q_r   <= '0;
                        n_r   <= '0;
                        i_r   <= '0;
                        sx_r  <= dvd_sign ^ dvs_sign;
                        mod_r <= sign_mod;
                        if (zero_dvs || zero_dvd) begin
                            res_q   <= '0;
                            res_r   <= '0;
                            res_s   <= dvd_sign ^ dvs_sign;
                            res_err <= zero_dvs;
                        end
                    end
                end
                ST_JOINT: begin
                    if (neither_norm) begin
                        a_r <= {a_r[MAG_W-1:0], 1'b0};
                        b_r <= {b_r[MAG_W-2:0], 1'b0};
                    end else if (only_dvs_norm) begin
                        res_q   <= '0;
                        res_r   <= a_r[MSB:0];
                        res_s   <= sx_r;
                        res_err <= 1'b0;
                    end
                end
                ST_ALIGN: begin
                    if (!b_r[MSB]) begin
                        b_r <= {b_r[MAG_W-2:0], 1'b0};
                        n_r <= n_r + CNT_W'(1);
                    end
                end
                ST_STEP: begin
                    a_r <= step_rem;
                    q_r <= step_q;
                    i_r <= i_r + CNT_W'(1);
                    if (last_step) begin
                        res_q   <= step_q;
                        res_r   <= step_rem[MSB:0];
                        res_s   <= mod_sign;
                        res_err <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        quo_mag  = res_q;
        rem_mag  = res_r;
        quo_sign = res_s;
        div_err  = res_err;
        done     = (state == ST_DONE);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo_mag) && $stable(rem_mag) && $stable(div_err)));

    // R2
    err_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> (quo_mag == '0 && rem_mag == '0));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP) |-> (a_r < {b_r, 1'b0}));

    // R4
    step_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP) |-> (b_r[MSB] && (i_r <= n_r)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE));
endmodule

// File: tb/smag_divider_bench.sv
`timescale 1ns/1ps
module smag_divider_bench;
    localparam int MAG_W = 35;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [MAG_W-1:0] dvd_mag;
    logic             dvd_sign;
    logic [MAG_W-1:0] dvs_mag;
    logic             dvs_sign;
    logic [1:0]       sign_mod;
    logic [MAG_W-1:0] quo_mag;
    logic             quo_sign;
    logic [MAG_W-1:0] rem_mag;
    logic             done;
    logic             div_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smag_divider u_smag_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_mag(dvd_mag), .dvd_sign(dvd_sign),
        .dvs_mag(dvs_mag), .dvs_sign(dvs_sign),
        .sign_mod(sign_mod),
        .quo_mag(quo_mag), .quo_sign(quo_sign), .rem_mag(rem_mag),
        .done(done), .div_err(div_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lz35(input longint v);
        for (int i = MAG_W - 1; i >= 0; i--)
            if (v[i]) return MAG_W - 1 - i;
        return MAG_W;
    endfunction

    function automatic bit apply_mod(input bit s, input logic [1:0] m);
        case (m)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~s;
            default: return s;
        endcase
    endfunction

    task automatic run_op(input longint a, input longint b, input bit sa, input bit sb,
                          input logic [1:0] m, input bit poke, input string tag);
        int lat;
        longint eq, er;
        bit es, ee;
        int la, lb;
        ee = 1'b0;
        es = sa ^ sb;
        eq = 0;
        er = 0;
        if (b == 0) begin
            lat = 1; ee = 1'b1;
        end else if (a == 0) begin
            lat = 1;
        end else begin
            la = lz35(a);
            lb = lz35(b);
            er = (a % b) << lb;
            if (lb < la) begin
                lat = lb + 2;
            end else begin
                lat = la + 2 * (lb - la) + 4;
                eq  = a / b;
                es  = apply_mod(sa ^ sb, m);
            end
        end
        @(negedge clk);
        dvd_mag  = a[MAG_W-1:0];
        dvs_mag  = b[MAG_W-1:0];
        dvd_sign = sa;
        dvs_sign = sb;
        sign_mod = m;
        start    = 1'b1;
        for (int c = 1; c <= lat + 2; c++) begin
            @(negedge clk);
            if (c == 1 || c == 3 || c == lat + 1) start = 1'b0;
            if (poke && ((c == 2 && lat > 3) || c == lat)) begin
                // R9: spurious start while busy or in the done cycle
                start    = 1'b1;
                dvd_mag  = 35'd123;
                dvs_mag  = '0;
                dvd_sign = ~sa;
                sign_mod = ~m;
            end
            chk(done == (c == lat), "R7 done timing", longint'(done), longint'(c == lat));
            if (c >= lat) begin
                chk(quo_mag == eq[MAG_W-1:0], {tag, " quotient"}, longint'(quo_mag), eq);
                chk(rem_mag == er[MAG_W-1:0], {tag, " remainder"}, longint'(rem_mag), er);
                chk(quo_sign == es, {tag, " sign"}, longint'(quo_sign), longint'(es));
                chk(div_err == ee, {tag, " error"}, longint'(div_err), longint'(ee));
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint seed = 64'h1234_5678_9abc_def1;
        longint mask = (64'd1 << MAG_W) - 1;
        rst_n = 1'b0;
        start = 1'b0;
        dvd_mag = '0; dvs_mag = '0; dvd_sign = 1'b0; dvs_sign = 1'b0; sign_mod = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10 done", longint'(done), 0);
        chk(div_err == 1'b0, "R10 err", longint'(div_err), 0);
        chk(quo_mag == '0 && quo_sign == 1'b0, "R10 quotient", longint'(quo_mag), 0);
        chk(rem_mag == '0, "R10 remainder", longint'(rem_mag), 0);

        // R1 / R4 / R7 full path
        run_op(100, 7, 1'b0, 1'b1, 2'b00, 1'b0, "R1");
        run_op((64'd1 << 34) + 5, (64'd1 << 34) + 3, 1'b1, 1'b1, 2'b00, 1'b0, "R4");
        run_op(mask, 1, 1'b0, 1'b0, 2'b00, 1'b0, "R4");
        run_op(1000000, 1000000, 1'b1, 1'b0, 2'b00, 1'b0, "R1");
        run_op(5, 7, 1'b0, 1'b0, 2'b00, 1'b0, "R4");
        // R2 zero divisor
        run_op(77, 0, 1'b1, 1'b0, 2'b10, 1'b0, "R2");
        // R3 zero dividend, modifier ignored
        run_op(0, 5, 1'b1, 1'b0, 2'b01, 1'b0, "R3");
        // R5 shortcut, modifier ignored
        run_op(3, 64'd1 << 33, 1'b1, 1'b0, 2'b01, 1'b0, "R5");
        run_op(12345, 64'd3 << 32, 1'b0, 1'b0, 2'b10, 1'b0, "R5");
        // R6 modifier codes
        run_op(999, 10, 1'b1, 1'b0, 2'b01, 1'b0, "R6");
        run_op(999, 10, 1'b0, 1'b0, 2'b10, 1'b0, "R6");
        run_op(999, 10, 1'b1, 1'b0, 2'b11, 1'b0, "R6");
        // R9 starts while busy and in done cycle
        run_op(123456789, 4321, 1'b0, 1'b1, 2'b00, 1'b1, "R9");
        run_op(0, 9, 1'b0, 1'b0, 2'b00, 1'b1, "R9");
        run_op(7, 64'd1 << 34, 1'b0, 1'b0, 2'b00, 1'b1, "R9");
        // R4 / R8 mixed patterns
        for (int t = 0; t < 24; t++) begin
            longint a, b;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            a = ((seed >>> 17) & mask) >> (seed & 15);
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            b = ((seed >>> 13) & mask) >> (seed & 31);
            run_op(a, b, seed[40], seed[41], seed[43:42], seed[44], "R8");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule